// File: doc/BRIEF.md
# Processor Reset Supervisor

This block decides when a processor is held in reset. It watches a supply-good indicator that has already been synchronized, a shared open-drain reset line, and a watchdog strobe from the processor. It drives the reset line low whenever the processor must not run. Every interval is counted in pulses of a one-millisecond enable input, `tick_ms`. The interval lengths are parameters, so a fast bench can shrink them.

The reset line is a single wire-ANDed pin that serves two purposes. The block pulls it low through `rst_n_o` and reads the pin level back through `rst_pin_i`. An external pushbutton can also pull the same pin low. A press starts a fixed-length reset. If the button is still held when that reset ends, the block waits for the release and then issues a second reset of the same length.

A watchdog runs only while the block is releasing the reset line. Its period comes from a two-bit code written through a simple write strobe. Each falling edge of the strobe input restarts the count, and so does each write of a new code. If the count reaches the selected period, the block issues a reset.

Top module: `proc_supervisor`

## Requirements
- R1: While `pwr_ok` is low, `rst_n_o` is low. It goes low on the first clock edge that samples `pwr_ok` low.
- R2: After `rst_n` is released, or after `pwr_ok` returns high, `rst_n_o` stays low for HOLD_TICKS ticks and is then released. `rst_n_o` is low while `rst_n` is asserted.
- R3: While the block releases the line, a falling edge on the synchronized `rst_pin_i` counts as a press. The block then holds `rst_n_o` low for HOLD_TICKS ticks.
- R4: After the press interval, the block releases the line for SETTLE_CYC cycles and then looks at the line. If the line is high, normal operation resumes and no second reset occurs. If the line is low, the block waits for it to go high and then holds `rst_n_o` low for another HOLD_TICKS ticks.
- R5: The watchdog code takes these values: 2'b00 disables the watchdog, 2'b01 selects WD_SHORT ticks, 2'b10 selects WD_MID ticks and 2'b11 selects WD_LONG ticks. The code is 2'b11 after `rst_n`, and `wd_we` loads it from `wd_sel`.
- R6: The watchdog counts ticks only while the block releases the line. When the count reaches the selected period, `rst_n_o` goes low for HOLD_TICKS ticks.
- R7: A falling edge of the synchronized `wd_kick` restarts the watchdog count from zero. A rising edge has no effect.
- R8: A write through `wd_we` restarts the watchdog count from zero, even when the code written is unchanged.
- R9: A falling edge on the line while the block is driving it low neither starts a press sequence nor lengthens the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms | input | 1 | One-cycle enable pulse, once per millisecond |
| pwr_ok | input | 1 | Synchronized supply-in-tolerance indicator |
| rst_pin_i | input | 1 | Level read back from the shared reset pin |
| wd_kick | input | 1 | Watchdog strobe from the processor, asynchronous |
| wd_we | input | 1 | Write strobe for the watchdog code |
| wd_sel | input | 2 | Watchdog code to be written |
| rst_n_o | output | 1 | Active-low reset drive onto the shared pin |

## Verification
The assertions assume that `pwr_ok` is already synchronous to `clk` and that `tick_ms` is high for single cycles only. The strobe and the pin level may change at any time, because both pass through two flops before any edge is detected. The bench drives every input on the falling clock edge and issues a tick every fourth cycle. It models the pin as the wired-AND of `rst_n_o` and a button that pulls the pin low. A cycle-exact behavioural model predicts the drive on every clock. The stimulus covers presses that end inside the reset interval and presses that outlast it, power drops while the block is already in reset, and strobe or write patterns that land just inside and just outside each watchdog period.

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
  parameter int HOLD_TICKS = 250,
  parameter int WD_SHORT   = 250,
  parameter int WD_MID     = 500,
  parameter int WD_LONG    = 1000,
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       pwr_ok,
  input  logic       rst_pin_i,
  input  logic       wd_kick,
  input  logic       wd_we,
  input  logic [1:0] wd_sel,
  output logic       rst_n_o
);

  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int WW = $clog2(WD_LONG + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_PFAIL, S_HOLD, S_PRESS, S_SETTLE, S_WAIT, S_RUN} st_t;

  st_t           st;
  logic [HW-1:0] hcnt;
  logic [WW-1:0] wcnt;
  logic [WW-1:0] wd_lim;
  logic [SW-1:0] scnt;
  logic [1:0]    wd_code;
  logic [1:0]    k_sync, l_sync;
  logic          k_prev, l_prev;

  wire k_fall    = k_prev & ~k_sync[1];
  wire l_fall    = l_prev & ~l_sync[1];
  wire line_hi   = l_sync[1];
  wire hold_done = tick_ms && (hcnt == HW'(HOLD_TICKS - 1));
  wire wd_on     = (wd_code != 2'b00);
  wire wd_clr    = (st != S_RUN) || !wd_on || wd_we || k_fall;
  wire wd_expire = !wd_clr && tick_ms && (wcnt == wd_lim - WW'(1));

  always_comb begin
    case (wd_code)
      2'b01:   wd_lim = WW'(WD_SHORT);
      2'b10:   wd_lim = WW'(WD_MID);
      default: wd_lim = WW'(WD_LONG);
    endcase
  end

  assign rst_n_o = !((st == S_PFAIL) || (st == S_HOLD) || (st == S_PRESS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_sync <= 2'b11;
      l_sync <= 2'b11;
      k_prev <= 1'b1;
      l_prev <= 1'b1;
    end else begin
      k_sync <= {k_sync[0], wd_kick};
      l_sync <= {l_sync[0], rst_pin_i};
      k_prev <= k_sync[1];
      l_prev <= l_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wd_code <= 2'b11;
    else if (wd_we) wd_code <= wd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wcnt <= '0;
    else if (wd_clr)    wcnt <= '0;
    else if (tick_ms)   wcnt <= wd_expire ? '0 : wcnt + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_PFAIL;
      hcnt <= '0;
      scnt <= '0;
    end else if (!pwr_ok) begin
      st   <= S_PFAIL;
      hcnt <= '0;
    end else begin
      case (st)
        S_PFAIL: begin
          st   <= S_HOLD;
          hcnt <= '0;
        end
        S_HOLD, S_PRESS: begin
          if (hold_done) begin
            hcnt <= '0;
            scnt <= '0;
            st   <= (st == S_HOLD) ? S_RUN : S_SETTLE;
          end else if (tick_ms) begin
            hcnt <= hcnt + HW'(1);
          end
        end
        S_SETTLE: begin
          if (scnt == SW'(SETTLE_CYC - 1)) st <= line_hi ? S_RUN : S_WAIT;
          else                             scnt <= scnt + SW'(1);
        end
        S_WAIT: begin
          if (line_hi) begin
            st   <= S_HOLD;
            hcnt <= '0;
          end
        end
        default: begin
          if (l_fall) begin
            st   <= S_PRESS;
            hcnt <= '0;
          end else if (wd_expire) begin
            st   <= S_HOLD;
            hcnt <= '0;
          end
        end
      endcase
    end
  end

  a_r1_pfail_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !rst_n_o);

  a_r2_hold_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < HW'(HOLD_TICKS));

  a_r3_press_detected: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && pwr_ok && l_fall) |=> (st == S_PRESS && !rst_n_o));

  a_r9_press_not_retriggered: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRESS && pwr_ok) |=> (st == S_PRESS || st == S_SETTLE));

  a_r6_wd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wd_on |-> (wcnt < wd_lim));

  a_r7_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && pwr_ok && !l_fall && k_fall) |=> (wcnt == '0 && rst_n_o));

endmodule

// File: tb/test_proc_supervisor.sv
`timescale 1ns/1ps
module test_proc_supervisor;
  localparam int HOLD = 5, T1 = 6, T2 = 10, T3 = 20, SETTLE = 3;
  localparam int M_OFF = 0, M_STRETCH = 1, M_PRESS = 2, M_SETTLE = 3, M_WAIT = 4, M_FREE = 5;

  logic clk = 0, rst_n = 0, tick = 0, pwr_ok = 1, kick = 1, wd_we = 0, button = 0;
  logic [1:0] wd_sel = 2'b00;
  logic rst_n_o;
  wire  pin = rst_n_o & ~button;

  int total = 0, bad = 0, falls = 0, f0 = 0;
  string cur_req = "R2";
  bit done = 0;

  proc_supervisor #(.HOLD_TICKS(HOLD), .WD_SHORT(T1), .WD_MID(T2), .WD_LONG(T3),
    .SETTLE_CYC(SETTLE)) i_proc_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick), .pwr_ok(pwr_ok), .rst_pin_i(pin),
    .wd_kick(kick), .wd_we(wd_we), .wd_sel(wd_sel), .rst_n_o(rst_n_o));

  always #10 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 3);
  end

  bit kick_on = 0;
  int kdiv = 0;
  always @(negedge clk) if (kick_on) begin
    kdiv = (kdiv + 1) % 8;
    if (kdiv == 0) kick <= ~kick;
  end

  // behavioural reference
  int mode, left, wleft, code, ocode;
  bit sq[3], lq[3], mdrive, sf, lf, was_free, expire, line_now;

  function automatic int lim(int c);
    return (c == 1) ? T1 : (c == 2) ? T2 : (c == 3) ? T3 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = M_OFF; left = 0; code = 3; wleft = T3;
      for (int i = 0; i < 3; i++) begin sq[i] = 1; lq[i] = 1; end
    end else begin
      line_now = ~(mdrive | button);
      sf = sq[2] & ~sq[1];
      lf = lq[2] & ~lq[1];
      was_free = (mode == M_FREE);
      ocode = code;
      expire = was_free && code != 0 && tick && !sf && !wd_we && wleft == 1;
      if (!pwr_ok) mode = M_OFF;
      else case (mode)
        M_OFF: begin mode = M_STRETCH; left = HOLD; end
        M_STRETCH, M_PRESS: if (tick) begin
          if (left == 1) begin
            if (mode == M_STRETCH) mode = M_FREE;
            else begin mode = M_SETTLE; left = SETTLE; end
          end else left--;
        end
        M_SETTLE: if (left == 1) mode = lq[1] ? M_FREE : M_WAIT; else left--;
        M_WAIT: if (lq[1]) begin mode = M_STRETCH; left = HOLD; end
        default: if (lf) begin mode = M_PRESS; left = HOLD; end
                 else if (expire) begin mode = M_STRETCH; left = HOLD; end
      endcase
      if (wd_we) code = wd_sel;
      if (!was_free || wd_we || sf || ocode == 0) wleft = lim(code);
      else if (tick) wleft = (wleft == 1) ? lim(code) : wleft - 1;
      sq[2] = sq[1]; sq[1] = sq[0]; sq[0] = kick;
      lq[2] = lq[1]; lq[1] = lq[0]; lq[0] = line_now;
    end
    mdrive = (mode == M_OFF || mode == M_STRETCH || mode == M_PRESS);
  end

  initial mdrive = 1;

  bit prev_o = 0;
  always @(negedge clk) if (!done) begin
    total++;
    if (rst_n_o !== ~mdrive) begin
      bad++;
      $display("FAIL %s: cycle compare rst_n_o=%0b expected=%0b at %0t", cur_req, rst_n_o, ~mdrive, $time);
    end
    if (prev_o && !rst_n_o) falls++;
    prev_o = rst_n_o;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] c);
    wd_we = 1; wd_sel = c;
    @(negedge clk);
    wd_we = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    cyc(200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
  end

  initial begin
    cyc(3);
    chk(rst_n_o == 0, "R2 low in reset", rst_n_o, 0);
    rst_n = 1;
    cyc(1);
    chk(rst_n_o == 0, "R2 stretch after reset", rst_n_o, 0);
    cyc(29);
    chk(rst_n_o == 1, "R2 released after stretch", rst_n_o, 1);

    cur_req = "R6"; f0 = falls;
    cyc(110);
    chk(falls == f0 + 1, "R6 default long timeout fires once", falls - f0, 1);

    cur_req = "R7"; kick_on = 1;
    cyc(30); f0 = falls;
    cyc(400);
    chk(falls == f0, "R7 kicks keep watchdog quiet", falls - f0, 0);
    kick_on = 0;

    cur_req = "R8"; wr(2'b01); f0 = falls;
    for (int i = 0; i < 12; i++) begin cyc(12); wr(2'b01); end
    chk(falls == f0, "R8 rewrite restarts count", falls - f0, 0);
    cur_req = "R5"; f0 = falls;
    cyc(60);
    chk(falls == f0 + 1, "R5 short code timeout", falls - f0, 1);
    wr(2'b00);
    cyc(40); f0 = falls;
    cyc(500);
    chk(falls == f0 && rst_n_o == 1, "R5 code 00 disables", falls - f0, 0);

    cur_req = "R3"; f0 = falls;
    button = 1; cyc(4); button = 0;
    cyc(8);
    chk(rst_n_o == 0, "R3 press drives low", rst_n_o, 0);
    cyc(60);
    cur_req = "R4";
    chk(falls == f0 + 1 && rst_n_o == 1, "R4 short press single pulse", falls - f0, 1);

    f0 = falls;
    button = 1; cyc(40);
    chk(rst_n_o == 1, "R4 waiting for release", rst_n_o, 1);
    button = 0; cyc(60);
    chk(falls == f0 + 2 && rst_n_o == 1, "R4 long press two pulses", falls - f0, 2);

    cur_req = "R1"; f0 = falls;
    pwr_ok = 0; cyc(5);
    chk(rst_n_o == 0, "R1 low while supply bad", rst_n_o, 0);
    pwr_ok = 1; cyc(4);
    cur_req = "R9";
    button = 1; cyc(2); button = 0;
    cyc(60);
    chk(falls == f0 + 1 && rst_n_o == 1, "R9 press during reset ignored", falls - f0, 1);

    cur_req = "R6"; wr(2'b10); f0 = falls;
    cyc(10 * 4 + 10);
    chk(falls == f0 + 1, "R6 mid timeout fires", falls - f0, 1);
    wr(2'b00);
    cyc(40);
    summary();
  end
endmodule